// File: doc/BRIEF.md
# Descriptor-Chained Memory Transfer Channel

This block is one transfer channel that copies data in 8-byte beats from a source address to a target address. The work to do is not held in registers. It is described by a linked list of descriptors that sit in memory. Each descriptor holds four 32-bit words: a link to the next descriptor, a source address, a target address and a command word. The command word selects the transfer length and the burst size. It also says whether each address advances, and whether the channel waits for a peripheral request before it starts each burst. Typical use is draining a peripheral receive FIFO, which sits at a fixed address, into a buffer that grows through memory.

Software starts a run with a single-cycle pulse on the start input, together with the address of the first descriptor. The channel then fetches that descriptor and performs its bursts. After that it follows the link word to the next descriptor. A descriptor whose link word has its stop bit set ends the chain. The channel then goes idle and raises a done flag.

The channel reads and writes memory through two 64-bit ports that use valid/ready handshakes. The channel holds a read or write request, with its address and data, stable until the matching ready arrives. Read data returns later on a response strobe. The response has no back-pressure: the channel waits for it and always takes it. At most one read is outstanding at any time.

Top module: `ldma_channel`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `rd_valid_o` and `wr_valid_o` are all low.
- R2: On a start, the descriptor is fetched as two 64-bit reads: one at the start address with bits [3:0] forced to zero, then one at that base plus 8. First read: bits [31:0] are the link word and bits [63:32] are the source address. Second read: bits [31:0] are the target address and bits [63:32] are the command word.
- R3: Command word fields: bit 31 advances the source address; bit 30 advances the target address; bit 29 is source flow control; bit 28 is target flow control; bits [17:16] select the burst; bits [12:0] give the length in bytes. All other bits are ignored.
- R4: Each beat reads 8 bytes from the current source address and then writes them to the current target address. After a beat, an address whose advance bit is set moves up by 8, and an address whose advance bit is clear stays put.
- R5: A descriptor performs length/8 beats; length bits [2:0] are dropped. A descriptor with fewer than 8 bytes moves nothing, and the channel goes straight on to its link.
- R6: When either flow-control bit is set, a burst begins only on a cycle where `periph_req_i` is high. Once a burst has begun, it runs to completion whatever the request does.
- R7: A burst is 4 beats for select 3, 2 beats for select 2, and 1 beat for select 1 or 0. The final burst of a descriptor is cut down to the beats that remain.
- R8: Bit 0 of the link word is the stop bit. When it is clear, the next descriptor is fetched from the link word with bits [3:0] cleared.
- R9: When the stop descriptor has finished, `busy_o` falls and `done_o` rises together. `done_o` stays high until the next accepted start, which clears it.
- R10: A read request, or a write request, keeps its valid, its address and (for a write) its data stable until the matching ready is seen.
- R11: A start pulse that arrives while the channel is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Single-cycle run request, taken only when idle |
| first_desc_i | input | 32 | Address of the first descriptor |
| periph_req_i | input | 1 | Peripheral request that gates bursts under flow control |
| busy_o | output | 1 | Channel is walking a chain |
| done_o | output | 1 | Sticky flag: the chain has ended |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | 32 | Read byte address, 8-byte aligned |
| rd_ready_i | input | 1 | Memory accepts the read request |
| rd_rvalid_i | input | 1 | Read data strobe for the outstanding read |
| rd_rdata_i | input | 64 | Read data |
| wr_valid_o | output | 1 | Write request valid |
| wr_addr_o | output | 32 | Write byte address |
| wr_data_o | output | 64 | Write data |
| wr_ready_i | input | 1 | Memory accepts the write |

## Verification
The assertions assume the memory side behaves: it never raises a read-data strobe unless a read has been accepted and is still waiting, and it gives exactly one strobe per accepted read. They also assume descriptors and data addresses are 8-byte aligned and that lengths fit their field. The stimulus respects these rules. A memory model in the bench answers each accepted read once, after a random delay of zero to two cycles, and grants ready at random. It places descriptors on 16-byte boundaries, sometimes with junk in the low link bits. It also keeps every source and target region inside the model's memory and away from the descriptor area.

// File: rtl/ldma_pkg.sv
`timescale 1ns/1ps
package ldma_pkg;
  localparam int WORD_W     = 32;
  localparam int BEAT_BYTES = 8;
  localparam int BUS_W      = BEAT_BYTES * 8;
  localparam int LEN_W      = 13;
  localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);
  localparam int BEATS_W    = LEN_W - BEAT_SHIFT;
  localparam int ALIGN_BITS = 4;
  localparam int MAX_BURST  = 4;
  localparam int BURST_CW   = $clog2(MAX_BURST) + 1;

  // command word view; bit positions are part of the descriptor format
  typedef struct packed {
    logic             inc_src;
    logic             inc_trg;
    logic             flow_src;
    logic             flow_trg;
    logic [9:0]       rsvd_hi;
    logic [1:0]       burst_sel;
    logic [2:0]       rsvd_lo;
    logic [LEN_W-1:0] len;
  } cmd_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR_REQ, ST_HDR_WAIT, ST_CMD_REQ, ST_CMD_WAIT,
    ST_GAP, ST_SRC_REQ, ST_SRC_WAIT, ST_DST_REQ, ST_LINK
  } state_t;
endpackage

// File: rtl/ldma_cmd_decode.sv
`timescale 1ns/1ps
module ldma_cmd_decode
  import ldma_pkg::*;
(
  input  logic [WORD_W-1:0]   cmd_word,
  output logic [BEATS_W-1:0]  total_beats,
  output logic [BURST_CW-1:0] burst_beats,
  output logic                needs_req,
  output logic                src_step,
  output logic                trg_step
);
  cmd_t c;
  logic unused_cmd_bits;

  assign c               = cmd_t'(cmd_word);
  assign total_beats     = c.len[LEN_W-1:BEAT_SHIFT];
  assign needs_req       = c.flow_src | c.flow_trg;
  assign src_step        = c.inc_src;
  assign trg_step        = c.inc_trg;
  assign unused_cmd_bits = ^{c.rsvd_hi, c.rsvd_lo, c.len[BEAT_SHIFT-1:0]};

  always_comb begin
    case (c.burst_sel)
      2'd3:    burst_beats = BURST_CW'(MAX_BURST);
      2'd2:    burst_beats = BURST_CW'(MAX_BURST / 2);
      default: burst_beats = BURST_CW'(1);
    endcase
  end
endmodule

// File: rtl/ldma_beat_ctr.sv
`timescale 1ns/1ps
module ldma_beat_ctr
  import ldma_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_total,
  input  logic [BEATS_W-1:0]  total_in,
  input  logic                open_burst,
  input  logic [BURST_CW-1:0] burst_in,
  input  logic                beat_done,
  output logic                burst_last,
  output logic                chain_empty
);
  logic [BEATS_W-1:0]  beats_q;
  logic [BURST_CW-1:0] burst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beats_q <= '0;
      burst_q <= '0;
    end else if (load_total) begin
      beats_q <= total_in;
      burst_q <= '0;
    end else if (open_burst) begin
      burst_q <= (beats_q < BEATS_W'(burst_in)) ? BURST_CW'(beats_q) : burst_in;
    end else if (beat_done) begin
      beats_q <= beats_q - 1'b1;
      burst_q <= burst_q - 1'b1;
    end
  end

  assign burst_last  = (burst_q == BURST_CW'(1));
  assign chain_empty = (beats_q == '0);

  // a beat may only complete while both counts still hold work
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |-> (beats_q != '0) && (burst_q != '0));

  // an opened burst never exceeds the selected size (R7)
  assert_burst_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(open_burst) |-> (burst_q <= $past(burst_in)) && (burst_q != '0));
endmodule

// File: rtl/ldma_addr_gen.sv
`timescale 1ns/1ps
module ldma_addr_gen
  import ldma_pkg::*;
#(
  parameter int STEP = BEAT_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              step_en,
  input  logic              inc,
  output logic [WORD_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n)                addr <= '0;
    else if (load)             addr <= load_val;
    else if (step_en && inc)   addr <= addr + WORD_W'(STEP);
  end

  assert_fixed_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !inc && !load) |=> $stable(addr));
endmodule

// File: rtl/ldma_channel.sv
`timescale 1ns/1ps
module ldma_channel
  import ldma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] first_desc_i,
  input  logic              periph_req_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_addr_o,
  input  logic              rd_ready_i,
  input  logic              rd_rvalid_i,
  input  logic [BUS_W-1:0]  rd_rdata_i,
  output logic              wr_valid_o,
  output logic [WORD_W-1:0] wr_addr_o,
  output logic [BUS_W-1:0]  wr_data_o,
  input  logic              wr_ready_i
);
  localparam int PTR_W = WORD_W - ALIGN_BITS;
  localparam int N_PTR = 2; // 0 = source, 1 = target

  state_t                  state_q;
  logic [PTR_W-1:0]        desc_q;
  logic [WORD_W-1:0]       link_q;
  logic [WORD_W-1:0]       cmd_q;
  logic [BUS_W-1:0]        buf_q;
  logic                    done_q;

  logic [WORD_W-1:0]       cmd_src;
  logic [BEATS_W-1:0]      total_beats;
  logic [BURST_CW-1:0]     burst_beats;
  logic                    needs_req, src_step, trg_step;
  logic                    cmd_arrive, hdr_arrive, open_burst, beat_done;
  logic                    burst_last, chain_empty;
  logic [WORD_W-1:0]       ptr_addr [N_PTR];
  logic [N_PTR-1:0]        ptr_load, ptr_inc;
  logic [WORD_W-1:0]       ptr_val  [N_PTR];
  logic                    unused_low;

  assign hdr_arrive = (state_q == ST_HDR_WAIT) && rd_rvalid_i;
  assign cmd_arrive = (state_q == ST_CMD_WAIT) && rd_rvalid_i;
  assign cmd_src    = cmd_arrive ? rd_rdata_i[BUS_W-1:WORD_W] : cmd_q;
  assign open_burst = (state_q == ST_GAP) && !chain_empty && (!needs_req || periph_req_i);
  assign beat_done  = (state_q == ST_DST_REQ) && wr_ready_i;
  assign unused_low = ^{link_q[ALIGN_BITS-1:1], first_desc_i[ALIGN_BITS-1:0]};

  ldma_cmd_decode u_dec (
    .cmd_word(cmd_src), .total_beats(total_beats), .burst_beats(burst_beats),
    .needs_req(needs_req), .src_step(src_step), .trg_step(trg_step)
  );

  ldma_beat_ctr u_beats (
    .clk(clk), .rst_n(rst_n), .load_total(cmd_arrive), .total_in(total_beats),
    .open_burst(open_burst), .burst_in(burst_beats), .beat_done(beat_done),
    .burst_last(burst_last), .chain_empty(chain_empty)
  );

  assign ptr_load = {cmd_arrive, hdr_arrive};
  assign ptr_inc  = {trg_step, src_step};
  assign ptr_val[0] = rd_rdata_i[BUS_W-1:WORD_W];
  assign ptr_val[1] = rd_rdata_i[WORD_W-1:0];

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    ldma_addr_gen u_ptr (
      .clk(clk), .rst_n(rst_n), .load(ptr_load[g]), .load_val(ptr_val[g]),
      .step_en(beat_done), .inc(ptr_inc[g]), .addr(ptr_addr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      desc_q  <= '0;
      link_q  <= '0;
      cmd_q   <= '0;
      buf_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          desc_q  <= first_desc_i[WORD_W-1:ALIGN_BITS];
          done_q  <= 1'b0;
          state_q <= ST_HDR_REQ;
        end
        ST_HDR_REQ:  if (rd_ready_i) state_q <= ST_HDR_WAIT;
        ST_HDR_WAIT: if (rd_rvalid_i) begin
          link_q  <= rd_rdata_i[WORD_W-1:0];
          state_q <= ST_CMD_REQ;
        end
        ST_CMD_REQ:  if (rd_ready_i) state_q <= ST_CMD_WAIT;
        ST_CMD_WAIT: if (rd_rvalid_i) begin
          cmd_q   <= rd_rdata_i[BUS_W-1:WORD_W];
          state_q <= ST_GAP;
        end
        ST_GAP: begin
          if (chain_empty)     state_q <= ST_LINK;
          else if (open_burst) state_q <= ST_SRC_REQ;
        end
        ST_SRC_REQ:  if (rd_ready_i) state_q <= ST_SRC_WAIT;
        ST_SRC_WAIT: if (rd_rvalid_i) begin
          buf_q   <= rd_rdata_i;
          state_q <= ST_DST_REQ;
        end
        ST_DST_REQ:  if (wr_ready_i) state_q <= burst_last ? ST_GAP : ST_SRC_REQ;
        ST_LINK: begin
          if (link_q[0]) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            desc_q  <= link_q[WORD_W-1:ALIGN_BITS];
            state_q <= ST_HDR_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_addr_o = ptr_addr[0];
    if (state_q == ST_HDR_REQ)      rd_addr_o = {desc_q, ALIGN_BITS'(0)};
    else if (state_q == ST_CMD_REQ) rd_addr_o = {desc_q, ALIGN_BITS'(BEAT_BYTES)};
  end

  assign rd_valid_o = (state_q == ST_HDR_REQ) || (state_q == ST_CMD_REQ) || (state_q == ST_SRC_REQ);
  assign wr_valid_o = (state_q == ST_DST_REQ);
  assign wr_addr_o  = ptr_addr[1];
  assign wr_data_o  = buf_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> rd_valid_o && $stable(rd_addr_o));

  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

  assert_req_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SRC_REQ && $past(state_q) == ST_GAP && needs_req) |-> $past(periph_req_i));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_fetch_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && state_q != ST_SRC_REQ) |-> (rd_addr_o[BEAT_SHIFT-1:0] == '0));
endmodule

// File: tb/ldma_channel_tb.sv
`timescale 1ns/1ps
module ldma_channel_tb_top;
  import ldma_pkg::*;

  localparam logic [31:0] FIFO_ADDR = 32'h0001_0000;
  localparam int MEM_WORDS = 1024;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start, preq;
  logic [31:0] first_desc;
  logic        busy, done, rd_valid, rd_ready, rd_rvalid, wr_valid, wr_ready;
  logic [31:0] rd_addr, wr_addr;
  logic [63:0] rd_rdata, wr_data;

  logic [63:0] mem     [0:MEM_WORDS-1];
  logic [63:0] exp_mem [0:MEM_WORDS-1];
  logic [31:0] fetch_addr [0:15];
  int n_checks = 0, n_bad = 0;
  int fifo_hw = 0, fifo_mod = 0, wr_n = 0, data_rd_n = 0, fetch_n = 0;
  int req_mode = 0, r10_bad = 0, rsp_wait = 0;
  bit rsp_pend = 0, prev_rd_wait = 0;
  logic [63:0] rsp_data;
  logic [31:0] prev_rd_addr;

  ldma_channel dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .first_desc_i(first_desc),
    .periph_req_i(preq), .busy_o(busy), .done_o(done),
    .rd_valid_o(rd_valid), .rd_addr_o(rd_addr), .rd_ready_i(rd_ready),
    .rd_rvalid_i(rd_rvalid), .rd_rdata_i(rd_rdata),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_ready_i(wr_ready)
  );

  function automatic logic [63:0] fifo_val(input int n);
    return 64'hF1F0_0000_0000_0000 | 64'(n);
  endfunction

  function automatic logic [31:0] mk_cmd(input bit si, input bit ti, input bit sf, input bit tf,
                                         input int bsel, input int len);
    return {si, ti, sf, tf, 10'b0, 2'(bsel), 3'b0, 13'(len)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] nx, input logic [31:0] s,
                          input logic [31:0] t, input logic [31:0] c);
    mem[a[12:3]]     = {s, nx};
    mem[a[12:3] + 1] = {c, t};
  endtask

  task automatic fill_mem();
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = {$urandom, $urandom};
  endtask

  task automatic snap_exp();
    for (int i = 0; i < MEM_WORDS; i++) exp_mem[i] = mem[i];
  endtask

  // independent walk of the chain following the requirement text
  task automatic model_chain(input logic [31:0] a);
    logic [31:0] p, nx, s, t, c;
    int idx, beats;
    logic [63:0] v;
    p = a & ~32'hF;
    forever begin
      idx   = int'(p[12:3]);
      nx    = exp_mem[idx][31:0];
      s     = exp_mem[idx][63:32];
      t     = exp_mem[idx + 1][31:0];
      c     = exp_mem[idx + 1][63:32];
      beats = int'(c[12:3]);
      for (int b = 0; b < beats; b++) begin
        if (s == FIFO_ADDR) begin v = fifo_val(fifo_mod); fifo_mod++; end
        else v = exp_mem[s[12:3]];
        exp_mem[t[12:3]] = v;
        if (c[31]) s = s + 8;
        if (c[30]) t = t + 8;
      end
      if (nx[0]) break;
      p = nx & ~32'hF;
    end
  endtask

  task automatic compare_mem(input string tag);
    int bad = 0, fi = 0;
    for (int i = 0; i < MEM_WORDS; i++)
      if (mem[i] !== exp_mem[i]) begin
        if (bad == 0) fi = i;
        bad++;
      end
    chk(bad == 0, tag, mem[fi], exp_mem[fi]);
  endtask

  task automatic pulse_start(input logic [31:0] a);
    @(negedge clk);
    first_desc = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
  endtask

  // memory and peripheral model, driven between clock edges
  initial begin
    rd_ready = 0; rd_rvalid = 0; rd_rdata = '0; wr_ready = 0; preq = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        rsp_pend = 0; rd_ready = 0; rd_rvalid = 0; wr_ready = 0; prev_rd_wait = 0;
      end else begin
        if (prev_rd_wait && (!rd_valid || rd_addr != prev_rd_addr)) r10_bad++;
        rd_rvalid = 0;
        if (rsp_pend) begin
          if (rsp_wait == 0) begin rd_rvalid = 1; rd_rdata = rsp_data; rsp_pend = 0; end
          else rsp_wait--;
        end
        rd_ready = 0;
        prev_rd_wait = 0;
        if (rd_valid && !rsp_pend) begin
          if ($urandom % 4 != 0) begin
            rd_ready = 1; rsp_pend = 1; rsp_wait = int'($urandom % 3);
            if (rd_addr == FIFO_ADDR) begin rsp_data = fifo_val(fifo_hw); fifo_hw++; end
            else rsp_data = mem[rd_addr[12:3]];
            if (rd_addr < 32'h400) begin
              if (fetch_n < 16) fetch_addr[fetch_n] = rd_addr;
              fetch_n++;
            end else data_rd_n++;
          end else begin
            prev_rd_wait = 1; prev_rd_addr = rd_addr;
          end
        end
        wr_ready = 0;
        if (wr_valid && ($urandom % 4 != 0)) begin
          wr_ready = 1; mem[wr_addr[12:3]] = wr_data; wr_n++;
        end
        if (req_mode == 0) preq = ($urandom % 3) != 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    int f0, t;
    logic [31:0] d0;
    void'($urandom(32'd20250917));
    rst_n = 0; start = 0; first_desc = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_valid && !wr_valid, "R1 reset outputs",
        {busy, done, rd_valid, wr_valid}, 4'b0);
    rst_n = 1;
    @(negedge clk);

    // R2/R4: single descriptor, misaligned start address, burst select 2
    fill_mem();
    put_desc(32'h000, 32'h1, 32'h400, 32'h800, mk_cmd(1, 1, 0, 0, 2, 32));
    snap_exp(); model_chain(32'h000);
    fetch_n = 0;
    @(negedge clk); first_desc = 32'h5; start = 1;
    @(negedge clk); start = 0;
    chk(busy && !done, "R9 start raises busy", {busy, done}, 2'b10);
    wait_done();
    chk(fetch_n == 2 && fetch_addr[0] == 32'h0 && fetch_addr[1] == 32'h8, "R2 fetch addresses",
        {fetch_addr[0], fetch_addr[1]}, {32'h0, 32'h8});
    compare_mem("R4 incrementing copy");
    chk(done && !busy, "R9 done after stop", {busy, done}, 2'b01);

    // R5/R8: zero-length descriptor linked (junk low bits) to fixed-target FIFO drain of 28 bytes
    fill_mem();
    put_desc(32'h040, 32'h084, 32'h400, 32'h900, mk_cmd(1, 1, 0, 0, 3, 0));
    put_desc(32'h080, 32'h1, FIFO_ADDR, 32'hA00, mk_cmd(0, 0, 0, 0, 1, 28));
    snap_exp(); f0 = fifo_mod; model_chain(32'h040);
    fetch_n = 0; wr_n = 0;
    pulse_start(32'h040);
    chk(!done, "R9 start clears done", 64'(done), 0);
    wait_done();
    chk(fetch_n == 4 && fetch_addr[2] == 32'h80, "R8 link followed", 64'(fetch_addr[2]), 64'h80);
    chk(wr_n == 3, "R5 beats from length", 64'(wr_n), 3);
    chk(mem[32'hA00 >> 3] == fifo_val(f0 + 2), "R4 fixed target keeps last beat",
        mem[32'hA00 >> 3], fifo_val(f0 + 2));
    compare_mem("R3 fixed source and target");

    // R6/R7/R11: flow control with hand-driven request, burst of 4, late start ignored
    req_mode = 1; preq = 0;
    fill_mem();
    put_desc(32'h100, 32'h1, FIFO_ADDR, 32'hB00, mk_cmd(0, 1, 1, 0, 3, 64));
    put_desc(32'h140, 32'h1, 32'h400, 32'hC00, mk_cmd(1, 1, 0, 0, 1, 8));
    snap_exp(); model_chain(32'h100);
    data_rd_n = 0; wr_n = 0; fetch_n = 0;
    pulse_start(32'h100);
    repeat (100) @(negedge clk);
    chk(data_rd_n == 0 && busy, "R6 no burst without request", 64'(data_rd_n), 0);
    pulse_start(32'h140);
    preq = 1;
    t = 0;
    while (data_rd_n == 0 && t < 1000) begin @(negedge clk); t++; end
    preq = 0;
    repeat (100) @(negedge clk);
    chk(wr_n == 4, "R7 select 3 moves four beats", 64'(wr_n), 4);
    chk(busy && !done, "R6 waits for next request", {busy, done}, 2'b10);
    preq = 1;
    t = 0;
    while (data_rd_n <= 4 && t < 1000) begin @(negedge clk); t++; end
    preq = 0;
    wait_done();
    chk(wr_n == 8 && done, "R7 second burst completes chain", 64'(wr_n), 8);
    chk(fetch_n == 2, "R11 start while busy ignored", 64'(fetch_n), 2);
    compare_mem("R11 no stray descriptor run");
    req_mode = 0;

    // constrained random chains
    for (int it = 0; it < 24; it++) begin
      int nd;
      logic [31:0] nx, s, tg;
      bit si, fs;
      fill_mem();
      nd = 1 + int'($urandom % 3);
      for (int k = 0; k < nd; k++) begin
        logic [31:0] d;
        d  = 32'(k * 32'h40);
        nx = (k == nd - 1) ? 32'h1 : ((d + 32'h40) | 32'(($urandom % 8) << 1));
        fs = $urandom % 2;
        if (fs) begin s = FIFO_ADDR; si = 0; end
        else begin s = 32'h400 + 32'(($urandom % 16) * 8); si = $urandom % 2; end
        tg = 32'h800 + 32'(k * 32'h100) + 32'(($urandom % 8) * 8);
        put_desc(d, nx, s, tg, mk_cmd(si, $urandom % 2, $urandom % 2, $urandom % 2,
                                      int'($urandom % 4), int'($urandom % 128)));
      end
      d0 = 32'($urandom % 16);
      snap_exp(); model_chain(d0);
      pulse_start(d0);
      wait_done();
      chk(done && !busy, "R9 random chain ends", {busy, done}, 2'b01);
      compare_mem("R3 random chain contents");
    end

    chk(r10_bad == 0, "R10 request held until ready", 64'(r10_bad), 0);
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule